// File: doc/BRIEF.md
# Sequential Bisection Fuzzifier

This block turns a crisp 8-bit input into a 4-bit membership level for one linear segment of a triangular or trapezoidal membership function whose slope need not be an integer. The segment starts at a start point and climbs by one level every `slope_i` input steps. When the sign input is set, the segment is mirrored and falls instead. A support window, given by a lower and an upper bound, clips the segment. Any input outside that window, or below the start point, maps to level 0.

The level is found without a divider. A start strobe captures all operands. A clocked bisection then runs over the 16 level indices. Each step turns a candidate level into an input position (start point plus level times slope) and compares that position with the captured input. It then keeps the lower or the upper half of the remaining index range. The search stops early when a position matches the input exactly, and it never takes more than four steps. A registered done flag marks the result as valid. The level and the flag hold until the next accepted start.

Top module: `fz_bsearch_seq`

## Requirements
- R1: While reset is asserted, and after it is released until the first accepted start, `alpha_o` is 0 and `done_o` is 0. Reset is asynchronous and active low. Asserting it in the middle of a search abandons that search.
- R2: A start (`start_i` high at a rising edge) is accepted only when the block is idle or has finished. `done_o` is low after the accepting edge. A start that arrives while a search is in progress is ignored.
- R3: With `slope_neg_i`=0, `slope_i`>=1 and the input inside the support, the level is min(floor((x - start)/slope), 15).
- R4: With `slope_neg_i`=1, under the same conditions, the level is 15 minus the R3 value.
- R5: When x < `lbound_i`, x > `rbound_i`, or x < `start_pt_i`, the level is 0 for either sign.
- R6: When `slope_i`=0 and the input is inside the support, the level is 15 for a rising segment and 0 for a falling one.
- R7: `done_o` rises no later than the 6th rising edge after the accepting edge. This allows one load cycle and at most four search cycles.
- R8: The out-of-support case (R5) and the zero-slope case (R6) finish at the 2nd edge after the accepting edge, with no search cycles.
- R9: An input exactly at start+8·slope finishes at the 3rd edge. An input exactly at start+4·slope finishes at the 4th edge. An input that matches no candidate position (for example start+8·slope+1 with slope>=2) finishes at the 6th edge.
- R10: Operands are captured at the accepting edge, so input changes after that edge do not alter the result. `alpha_o` and `done_o` hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe; captures the operands |
| slope_neg_i | input | 1 | 0: rising segment, 1: falling (mirrored) segment |
| slope_i | input | 4 | Input steps per membership level |
| start_pt_i | input | 8 | Input position where the segment begins |
| lbound_i | input | 8 | Lower edge of the support window |
| rbound_i | input | 8 | Upper edge of the support window |
| x_i | input | 8 | Crisp input value |
| alpha_o | output | 4 | Membership level, valid while done_o is high |
| done_o | output | 1 | End-of-search flag |

## Verification
A wrong step in the bisection shows up as a level that is off by a power of two, or as a level from the wrong half of the index range. A wrong step-size register instead shows up as a done flag at the wrong edge. For these reasons the bench compares every result against a closed-form division model. It also pins the exact finishing edge for inputs that hit a candidate position at the first or second step, or that hit none. An early-exit path that misclassifies the support shows up two edges after the start as a nonzero level where 0 is expected. Full sweeps of the input over several slopes and signs show that a fault in any single step appears within the first few results.

// File: rtl/fz_bsearch_pkg.sv
package fz_bsearch_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOAD   = 2'd1,
    ST_SEARCH = 2'd2,
    ST_DONE   = 2'd3
  } fz_state_e;
endpackage

// File: rtl/fz_load.sv
// Operand capture and support classification.
module fz_load #(
  parameter int XW = 8,
  parameter int SW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_en_i,
  input  logic          slope_neg_i,
  input  logic [SW-1:0] slope_i,
  input  logic [XW-1:0] start_pt_i,
  input  logic [XW-1:0] lbound_i,
  input  logic [XW-1:0] rbound_i,
  input  logic [XW-1:0] x_i,
  output logic          slope_neg_o,
  output logic [SW-1:0] slope_o,
  output logic [XW-1:0] start_pt_o,
  output logic [XW-1:0] x_o,
  output logic          outside_o,
  output logic          flat_o
);
  logic          neg_q;
  logic [SW-1:0] slope_q;
  logic [XW-1:0] p1_q, lb_q, rb_q, x_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      neg_q   <= 1'b0;
      slope_q <= '0;
      p1_q    <= '0;
      lb_q    <= '0;
      rb_q    <= '0;
      x_q     <= '0;
    end else if (cap_en_i) begin
      neg_q   <= slope_neg_i;
      slope_q <= slope_i;
      p1_q    <= start_pt_i;
      lb_q    <= lbound_i;
      rb_q    <= rbound_i;
      x_q     <= x_i;
    end
  end

  always_comb begin
    outside_o = (x_q < lb_q) || (x_q > rb_q) || (x_q < p1_q);
    flat_o    = (slope_q == '0);
  end

  assign slope_neg_o = neg_q;
  assign slope_o     = slope_q;
  assign start_pt_o  = p1_q;
  assign x_o         = x_q;
endmodule

// File: rtl/fz_probe.sv
// Maps a candidate level to an input position and compares it with x.
module fz_probe #(
  parameter int XW = 8,
  parameter int SW = 4,
  parameter int LW = 4
) (
  input  logic [LW-1:0] lvl_i,
  input  logic [SW-1:0] slope_i,
  input  logic [XW-1:0] start_pt_i,
  input  logic [XW-1:0] x_i,
  output logic          below_o,
  output logic          equal_o
);
  localparam int PRW = LW + SW;
  localparam int PW  = ((XW > PRW) ? XW : PRW) + 1;

  logic [PRW-1:0] prod;
  logic [PW-1:0]  pos, xe;

  always_comb begin
    prod    = {{SW{1'b0}}, lvl_i} * {{LW{1'b0}}, slope_i};
    pos     = {{(PW-XW){1'b0}}, start_pt_i} + {{(PW-PRW){1'b0}}, prod};
    xe      = {{(PW-XW){1'b0}}, x_i};
    below_o = pos < xe;
    equal_o = pos == xe;
  end
endmodule

// File: rtl/fz_bisect.sv
// Bisection over level indices: lower index plus a power-of-two half span.
module fz_bisect #(
  parameter int XW = 8,
  parameter int SW = 4,
  parameter int LW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          init_en_i,
  input  logic          step_en_i,
  input  logic [SW-1:0] slope_i,
  input  logic [XW-1:0] start_pt_i,
  input  logic [XW-1:0] x_i,
  output logic          finish_o,
  output logic [LW-1:0] found_o,
  output logic [LW-1:0] lo_o,
  output logic [LW-1:0] half_o
);
  localparam logic [LW-1:0] HALF0 = {1'b1, {(LW-1){1'b0}}};

  logic [LW-1:0] lo_q, half_q, mid;
  logic          below, equal;

  assign mid = lo_q + half_q;

  fz_probe #(.XW(XW), .SW(SW), .LW(LW)) u_probe (
    .lvl_i      (mid),
    .slope_i    (slope_i),
    .start_pt_i (start_pt_i),
    .x_i        (x_i),
    .below_o    (below),
    .equal_o    (equal)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q   <= '0;
      half_q <= HALF0;
    end else if (init_en_i) begin
      lo_q   <= '0;
      half_q <= HALF0;
    end else if (step_en_i) begin
      if (below) lo_q <= mid;
      half_q <= half_q >> 1;
    end
  end

  always_comb begin
    finish_o = equal || (half_q == {{(LW-1){1'b0}}, 1'b1});
    found_o  = (equal || below) ? mid : lo_q;
  end

  assign lo_o   = lo_q;
  assign half_o = half_q;
endmodule

// File: rtl/fz_ctrl.sv
// Control FSM: idle, load/classify, search, done.
module fz_ctrl
  import fz_bsearch_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      start_i,
  input  logic      early_i,
  input  logic      finish_i,
  output fz_state_e state_o,
  output logic      cap_en_o,
  output logic      step_en_o,
  output logic      early_fin_o,
  output logic      step_fin_o
);
  fz_state_e state_q, state_d;

  always_comb begin
    cap_en_o    = start_i && ((state_q == ST_IDLE) || (state_q == ST_DONE));
    early_fin_o = (state_q == ST_LOAD) && early_i;
    step_en_o   = (state_q == ST_SEARCH);
    step_fin_o  = step_en_o && finish_i;
    state_d     = state_q;
    unique case (state_q)
      ST_IDLE, ST_DONE: if (cap_en_o) state_d = ST_LOAD;
      ST_LOAD:          state_d = early_i ? ST_DONE : ST_SEARCH;
      ST_SEARCH:        if (finish_i) state_d = ST_DONE;
      default:          state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/fz_level.sv
// Result register: applies clipping and mirroring, holds the done flag.
module fz_level #(
  parameter int LW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_en_i,
  input  logic          early_fin_i,
  input  logic          step_fin_i,
  input  logic          outside_i,
  input  logic          slope_neg_i,
  input  logic [LW-1:0] found_i,
  output logic [LW-1:0] alpha_o,
  output logic          done_o
);
  localparam logic [LW-1:0] FULL = '1;

  logic [LW-1:0] alpha_q, alpha_d;
  logic          done_q;

  always_comb begin
    if (early_fin_i) alpha_d = (outside_i || slope_neg_i) ? '0 : FULL;
    else             alpha_d = slope_neg_i ? (FULL - found_i) : found_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alpha_q <= '0;
      done_q  <= 1'b0;
    end else if (cap_en_i) begin
      done_q  <= 1'b0;
    end else if (early_fin_i || step_fin_i) begin
      alpha_q <= alpha_d;
      done_q  <= 1'b1;
    end
  end

  assign alpha_o = alpha_q;
  assign done_o  = done_q;
endmodule

// File: rtl/fz_bsearch_seq.sv
module fz_bsearch_seq
  import fz_bsearch_pkg::*;
#(
  parameter int XW = 8,
  parameter int SW = 4,
  parameter int LW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          slope_neg_i,
  input  logic [SW-1:0] slope_i,
  input  logic [XW-1:0] start_pt_i,
  input  logic [XW-1:0] lbound_i,
  input  logic [XW-1:0] rbound_i,
  input  logic [XW-1:0] x_i,
  output logic [LW-1:0] alpha_o,
  output logic          done_o
);
  fz_state_e     state_q;
  logic          cap_en, step_en, early_fin, step_fin, finish;
  logic          neg_q, outside, flat;
  logic [SW-1:0] slope_q;
  logic [XW-1:0] p1_q, x_q;
  logic [LW-1:0] found, lo_q, half_q;

  fz_load #(.XW(XW), .SW(SW)) u_load (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cap_en_i    (cap_en),
    .slope_neg_i (slope_neg_i),
    .slope_i     (slope_i),
    .start_pt_i  (start_pt_i),
    .lbound_i    (lbound_i),
    .rbound_i    (rbound_i),
    .x_i         (x_i),
    .slope_neg_o (neg_q),
    .slope_o     (slope_q),
    .start_pt_o  (p1_q),
    .x_o         (x_q),
    .outside_o   (outside),
    .flat_o      (flat)
  );

  fz_bisect #(.XW(XW), .SW(SW), .LW(LW)) u_bisect (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .init_en_i  (cap_en),
    .step_en_i  (step_en),
    .slope_i    (slope_q),
    .start_pt_i (p1_q),
    .x_i        (x_q),
    .finish_o   (finish),
    .found_o    (found),
    .lo_o       (lo_q),
    .half_o     (half_q)
  );

  fz_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .early_i     (outside || flat),
    .finish_i    (finish),
    .state_o     (state_q),
    .cap_en_o    (cap_en),
    .step_en_o   (step_en),
    .early_fin_o (early_fin),
    .step_fin_o  (step_fin)
  );

  fz_level #(.LW(LW)) u_level (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cap_en_i    (cap_en),
    .early_fin_i (early_fin),
    .step_fin_i  (step_fin),
    .outside_i   (outside),
    .slope_neg_i (neg_q),
    .found_i     (found),
    .alpha_o     (alpha_o),
    .done_o      (done_o)
  );
endmodule

// File: rtl/fz_bsearch_chk.sv
module fz_bsearch_chk
  import fz_bsearch_pkg::*;
#(
  parameter int LW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          done_o,
  input  logic [LW-1:0] alpha_o,
  input  fz_state_e     state_q,
  input  logic [LW-1:0] lo_q,
  input  logic [LW-1:0] half_q
);
  logic [2:0] srch_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     srch_cnt <= '0;
    else if (state_q == ST_SEARCH)   srch_cnt <= srch_cnt + 3'd1;
    else                             srch_cnt <= '0;
  end

  p_clear_on_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && (state_q == ST_IDLE || state_q == ST_DONE)) |=> !done_o);

  p_load_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LOAD) |=> (state_q != ST_LOAD));

  p_search_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SEARCH) |-> (srch_cnt < 3'd4));

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(alpha_o)));

  p_done_source_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> ($past(state_q) == ST_LOAD || $past(state_q) == ST_SEARCH));

  p_span_onehot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SEARCH) |-> ($onehot(half_q) && ({1'b0, lo_q} + {1'b0, half_q} < (LW+1)'(1 << LW))));

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> (!done_o && alpha_o == '0));
endmodule

bind fz_bsearch_seq fz_bsearch_chk #(.LW(LW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .done_o  (done_o),
  .alpha_o (alpha_o),
  .state_q (state_q),
  .lo_q    (lo_q),
  .half_q  (half_q)
);

// File: tb/fz_bsearch_seq_tb.sv
module fz_bsearch_seq_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic       slope_neg_i = 1'b0;
  logic [3:0] slope_i = '0;
  logic [7:0] start_pt_i = '0, lbound_i = '0, rbound_i = '0, x_i = '0;
  logic [3:0] alpha_o;
  logic       done_o;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  int    exp_q[$];
  string tag_q[$];
  logic  done_prev = 1'b0;

  always #10 clk_i = ~clk_i;

  fz_bsearch_seq u_dut (
    .clk_i, .rst_ni, .start_i, .slope_neg_i, .slope_i, .start_pt_i,
    .lbound_i, .rbound_i, .x_i, .alpha_o, .done_o
  );

  function automatic int model(bit s, int m, int p, int lb, int rb, int x);
    int r;
    if (x < lb || x > rb || x < p) return 0;
    if (m == 0) r = 15;
    else begin
      r = (x - p) / m;
      if (r > 15) r = 15;
    end
    return s ? 15 - r : r;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor: on each rising done flag, pop and compare the expected level.
  always @(negedge clk_i) begin
    if (done_o && !done_prev) begin
      if (exp_q.size() == 0) check("R2 unexpected result", 1, 0);
      else check(tag_q.pop_front(), int'(alpha_o), exp_q.pop_front());
    end
    done_prev <= done_o;
  end

  // Driver: push expected, strobe start, return latency in edges.
  task automatic run(bit s, int m, int p, int lb, int rb, int x, int exp_lat, string tag);
    int lat;
    exp_q.push_back(model(s, m, p, lb, rb, x));
    tag_q.push_back(tag);
    @(negedge clk_i);
    slope_neg_i = s; slope_i = 4'(m); start_pt_i = 8'(p);
    lbound_i = 8'(lb); rbound_i = 8'(rb); x_i = 8'(x);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    lat = 1;
    while (!done_o && lat < 40) begin
      @(negedge clk_i);
      lat++;
    end
    check("R7 latency bound", int'(lat <= 6), 1);
    if (exp_lat > 0) check({tag, " latency R8/R9"}, lat, exp_lat);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    int lat;
    // R1 reset state
    repeat (2) @(negedge clk_i);
    check("R1 alpha in reset", int'(alpha_o), 0);
    check("R1 done in reset", int'(done_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check("R1 alpha after reset", int'(alpha_o), 0);
    check("R1 done after reset", int'(done_o), 0);

    // R3 rising, R9 exact latencies
    run(0, 3, 40, 0, 255, 64, 3, "R3 hit mid8");
    run(0, 3, 40, 0, 255, 52, 4, "R3 hit mid4");
    run(0, 3, 40, 0, 255, 65, 6, "R3 no hit");
    run(0, 3, 40, 0, 255, 40, 6, "R3 at start");
    run(0, 3, 40, 0, 255, 200, 0, "R3 saturate");
    run(0, 7, 100, 0, 255, 150, 0, "R3 slope7");
    run(0, 1, 0, 0, 255, 15, 0, "R3 slope1");
    run(0, 15, 0, 0, 255, 255, 0, "R3 slope15");
    // R4 falling
    run(1, 3, 40, 0, 255, 65, 0, "R4 falling");
    run(1, 5, 10, 0, 255, 87, 0, "R4 falling low");
    run(1, 5, 10, 0, 255, 10, 0, "R4 falling top");
    // R5 / R8 out of support
    run(0, 3, 40, 0, 255, 39, 2, "R5 below start");
    run(0, 3, 40, 50, 120, 130, 2, "R5 above rbound");
    run(1, 3, 40, 50, 120, 45, 2, "R5 below lbound");
    run(0, 3, 40, 50, 120, 120, 0, "R5 at rbound");
    // R6 zero slope
    run(0, 0, 20, 0, 255, 20, 2, "R6 flat rising");
    run(1, 0, 20, 0, 255, 90, 2, "R6 flat falling");

    // Sweeps over the full input range
    for (int x = 0; x < 256; x++) run(0, 5, 30, 10, 240, x, 0, "R3 sweep");
    for (int x = 0; x < 256; x++) run(1, 9, 12, 0, 255, x, 0, "R4 sweep");
    for (int x = 0; x < 256; x += 3) run(0, 2, 0, 0, 200, x, 0, "R3 sweep s2");

    // R2/R10: start while busy and input changes after capture are ignored
    exp_q.push_back(model(0, 4, 20, 0, 255, 70));
    tag_q.push_back("R10 captured operands");
    @(negedge clk_i);
    slope_neg_i = 0; slope_i = 4; start_pt_i = 20; lbound_i = 0; rbound_i = 255; x_i = 70;
    start_i = 1'b1;
    @(negedge clk_i);
    x_i = 200; slope_i = 1; slope_neg_i = 1;
    @(negedge clk_i);
    @(negedge clk_i);
    start_i = 1'b0;
    lat = 3;
    while (!done_o && lat < 40) begin
      @(negedge clk_i);
      lat++;
    end
    check("R2 busy start ignored latency", lat, 6);
    repeat (4) @(negedge clk_i);
    check("R10 hold done", int'(done_o), 1);
    check("R10 hold alpha", int'(alpha_o), model(0, 4, 20, 0, 255, 70));

    // R2: done drops after accepted start
    @(negedge clk_i);
    start_pt_i = 0; slope_i = 2; x_i = 9; slope_neg_i = 0;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    check("R2 done cleared", int'(done_o), 0);
    exp_q.push_back(4);
    tag_q.push_back("R2 restart result");
    repeat (8) @(negedge clk_i);

    // R1: reset mid-search abandons it
    @(negedge clk_i);
    x_i = 33; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check("R1 reset mid-search alpha", int'(alpha_o), 0);
    check("R1 reset mid-search done", int'(done_o), 0);
    rst_ni = 1'b1;
    repeat (8) @(negedge clk_i);
    check("R1 no result after abort", int'(done_o), 0);

    check("R7 all results seen", exp_q.size(), 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule